// File: doc/BRIEF.md
# Serial Control Port for an Analog Front End

This block is the slave side of a three-wire control port for an analog front end. A host opens an access by pulling `sel_n` low and then toggles a gated serial clock `sclk`. The clock idles low and runs only inside an access. Command and write data enter on `sdi`. Read data leaves on `sdo`. Each access carries a direction bit, a register address and one data byte, all sent most significant bit first. The block keeps the gain codes for the receive and transmit amplifiers and a clock/PLL control byte, and drives them to the analog circuits. It also has a read-only status byte with a sticky flag that records ADC clipping.

The serial pins are sampled by the core clock `clk`. `clk` is synchronous to the host's port logic, and `clip_pulse` lasts one `clk` cycle. One sampling stage and an edge detector turn `sclk` into rise and fall events. Input bits are taken on falling events and output bits are launched on rising events. The configuration bank and the clip flag are ordinary core-clock registers, so they hold their values while `sclk` is stopped.

The access state machine uses six states:
- `ST_IDLE`: no access is open. It moves to `ST_HEAD` when `sel_n` is seen low.
- `ST_HEAD`: collects the direction bit and the address bits. On the fourth fall it moves to `ST_RDATA` if the direction bit is 1, or to `ST_WDATA` if it is 0.
- `ST_WDATA` or `ST_RDATA`: moves to `ST_TAIL` on the twelfth fall.
- `ST_TAIL`: moves to `ST_BAD` on any further fall.
- `ST_BAD`: waits for the access to end.

From every state other than `ST_IDLE`, a high `sel_n` returns the machine to `ST_IDLE`. A write or read is committed only when the machine leaves `ST_TAIL` in this way.

Top module: `afe_serctl`

## Requirements
- R1: After the asynchronous active-low reset, the outputs and read-back values are: receive gain 0x00, transmit gain 0x00, PLL control 0x40, clip flag clear, and `sdo` low.
- R2: An access is 12 `sclk` periods. The first bit is the direction (1 = read, 0 = write). Three address bits follow, then eight data bits, all MSB first. Every bit is sampled on a falling `sclk` edge.
- R3: Address 0 holds the receive gain code, 0 to 80 (0 dB to 40 dB in 0.5 dB steps). A written value above 80 is stored as 80.
- R4: Address 1 holds the transmit gain code, 0 to 16 (attenuation in 2 dB steps). A written value above 16 is stored as 16.
- R5: Address 4 holds the 8-bit PLL/clock control byte. All eight bits are stored as written.
- R6: In a read access, `sdo` carries the addressed byte MSB first. Each bit is launched after `sclk` rising edges 5 through 12. `sdo` is low during the header, outside read accesses, and after any rising edge past the twelfth.
- R7: An access with fewer or more than 12 `sclk` periods changes no register and does not clear the clip flag.
- R8: A write to address 7 (status) or to an unassigned address (2, 3, 5, 6) has no effect. A read of an unassigned address returns 0x00.
- R9: A one-cycle `clip_pulse` sets the clip flag. The flag is read at address 7 in bit 0, and bits 7 to 1 read as zero.
- R10: A complete read of address 7 that returned a 1 in bit 0 clears the clip flag. A pulse that arrives after the address phase of a read that returned 0 keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Gated serial clock, idles low |
| sel_n | input | 1 | Active-low access enable |
| sdi | input | 1 | Serial command and write data |
| clip_pulse | input | 1 | One-cycle ADC clip event |
| sdo | output | 1 | Serial read data |
| rx_gain | output | 8 | Receive amplifier gain code |
| tx_gain | output | 8 | Transmit amplifier gain code |
| pll_ctl | output | 8 | PLL / clock control byte |

## Verification
Every result the host can see changes exactly two core-clock edges after the serial pin change that causes it. This holds for an `sdo` bit after an `sclk` rise, for `sdo` returning low after `sel_n` rises, and for a gain output after the `sel_n` rise that commits a write. The bench drives pins on falling `clk` edges and updates its behavioural expectation at the same instant. It then samples 3 ns after each rising `clk` edge and compares the outputs with the expectation recorded one sample earlier, which is exactly that two-edge lag. The clip pulse is placed well after the fourth serial fall, so the byte snapshot taken at that fall is settled when the expected read value is computed.

// File: rtl/afe_serctl_pkg.sv
package afe_serctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_WDATA,
        ST_RDATA,
        ST_TAIL,
        ST_BAD
    } sc_state_t;

endpackage

// File: rtl/afe_serctl_sync.sv
module afe_serctl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sel_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_act,
    output logic sdi_s
);

    logic sclk_q, sclk_d, sel_q, sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            sel_q  <= 1'b1;
            sdi_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            sel_q  <= sel_n;
            sdi_q  <= sdi;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_d;
    assign sclk_fall = ~sclk_q & sclk_d;
    assign sel_act   = ~sel_q;
    assign sdi_s     = sdi_q;

endmodule

// File: rtl/afe_serctl_fsm.sv
module afe_serctl_fsm
    import afe_serctl_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              snap_load,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              commit_wr,
    output logic              commit_rd,
    output logic              sdo
);

    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FRAME_FULL = CNT_W'(FRAME_LEN);

    sc_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] in_sh;
    logic [DATA_W-1:0] out_sh;
    logic              rw_q;
    logic              sdo_q;
    logic              counting;

    assign counting  = (state == ST_HEAD) || (state == ST_WDATA) || (state == ST_RDATA);
    assign rd_addr   = {in_sh[ADDR_W-2:0], sdi_s};
    assign snap_load = (state == ST_HEAD) && sel_act && sclk_fall && (cnt == HDR_LAST);
    assign commit_wr = (state == ST_TAIL) && !sel_act && !rw_q;
    assign commit_rd = (state == ST_TAIL) && !sel_act && rw_q;
    assign sdo       = sdo_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sel_act) state_nx = ST_HEAD;
            end
            ST_HEAD: begin
                if (!sel_act)
                    state_nx = ST_IDLE;
                else if (sclk_fall && (cnt == HDR_LAST))
                    state_nx = in_sh[ADDR_W-1] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (!sel_act)
                    state_nx = ST_IDLE;
                else if (sclk_fall && (cnt == FRAME_LAST))
                    state_nx = ST_TAIL;
            end
            ST_TAIL: begin
                if (!sel_act)
                    state_nx = ST_IDLE;
                else if (sclk_fall)
                    state_nx = ST_BAD;
            end
            ST_BAD: begin
                if (!sel_act) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shift-in datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            in_sh    <= '0;
            rw_q     <= 1'b0;
            acc_addr <= '0;
            wdata    <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= '0;
        end else if (sel_act && sclk_fall && counting) begin
            cnt   <= cnt + CNT_W'(1);
            in_sh <= {in_sh[DATA_W-2:0], sdi_s};
            if (cnt == HDR_LAST) begin
                rw_q     <= in_sh[ADDR_W-1];
                acc_addr <= rd_addr;
            end
            if ((state == ST_WDATA) && (cnt == FRAME_LAST))
                wdata <= {in_sh[DATA_W-2:0], sdi_s};
        end
    end

    // output process: serial read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q  <= 1'b0;
            out_sh <= '0;
        end else if (!sel_act || (state == ST_IDLE)) begin
            sdo_q <= 1'b0;
        end else begin
            if (snap_load)
                out_sh <= rd_data;
            if (sclk_rise) begin
                if (state == ST_RDATA) begin
                    sdo_q  <= out_sh[DATA_W-1];
                    out_sh <= {out_sh[DATA_W-2:0], 1'b0};
                end else begin
                    sdo_q <= 1'b0;
                end
            end
        end
    end

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo_q);

    assert_head_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD) |-> !sdo_q);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FRAME_FULL);

    assert_commit_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr || commit_rd) |-> (cnt == FRAME_FULL));

endmodule

// File: rtl/afe_serctl_regs.sv
module afe_serctl_regs #(
    parameter int          ADDR_W    = 3,
    parameter int          DATA_W    = 8,
    parameter int          RX_MAX    = 80,
    parameter int          TX_MAX    = 16,
    parameter int          RX_RST    = 0,
    parameter int          TX_RST    = 0,
    parameter int          PLL_RST   = 'h40,
    parameter int          ADDR_RX   = 0,
    parameter int          ADDR_TX   = 1,
    parameter int          ADDR_PLL  = 4,
    parameter int          ADDR_STAT = 7,
    parameter bit          CLAMP_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_wr,
    input  logic              commit_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              snap_load,
    input  logic              clip_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rx_gain,
    output logic [DATA_W-1:0] tx_gain,
    output logic [DATA_W-1:0] pll_ctl
);

    localparam logic [DATA_W-1:0] RX_LIM = DATA_W'(RX_MAX);
    localparam logic [DATA_W-1:0] TX_LIM = DATA_W'(TX_MAX);
    localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(ADDR_RX);
    localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(ADDR_TX);
    localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(ADDR_PLL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic [DATA_W-1:0] rx_q, tx_q, pll_q;
    logic [DATA_W-1:0] rx_wv, tx_wv;
    logic              clip_flag, snap_q, clip_clr;

    function automatic logic [DATA_W-1:0] sat(input logic [DATA_W-1:0] v,
                                              input logic [DATA_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

    generate
        if (CLAMP_EN) begin : g_clamp
            assign rx_wv = sat(wdata, RX_LIM);
            assign tx_wv = sat(wdata, TX_LIM);
            assert_rx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                rx_q <= RX_LIM);
            assert_tx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tx_q <= TX_LIM);
        end else begin : g_raw
            assign rx_wv = wdata;
            assign tx_wv = wdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= DATA_W'(RX_RST);
            tx_q  <= DATA_W'(TX_RST);
            pll_q <= DATA_W'(PLL_RST);
        end else if (commit_wr) begin
            if (acc_addr == A_RX)  rx_q  <= rx_wv;
            if (acc_addr == A_TX)  tx_q  <= tx_wv;
            if (acc_addr == A_PLL) pll_q <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_RX)   rd_data = rx_q;
        if (rd_addr == A_TX)   rd_data = tx_q;
        if (rd_addr == A_PLL)  rd_data = pll_q;
        if (rd_addr == A_STAT) rd_data = {{(DATA_W-1){1'b0}}, clip_flag};
    end

    assign clip_clr = commit_rd && (acc_addr == A_STAT) && snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clip_flag <= 1'b0;
            snap_q    <= 1'b0;
        end else begin
            if (snap_load)
                snap_q <= (rd_addr == A_STAT) && clip_flag;
            clip_flag <= clip_pulse | (clip_flag & ~clip_clr);
        end
    end

    assign rx_gain = rx_q;
    assign tx_gain = tx_q;
    assign pll_ctl = pll_q;

    assert_clip_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clip_pulse |=> clip_flag);

    assert_clip_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_flag && !commit_rd) |=> clip_flag);

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_wr |=> ($stable(rx_q) && $stable(tx_q) && $stable(pll_q)));

endmodule

// File: rtl/afe_serctl.sv
module afe_serctl #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int RX_MAX    = 80,
    parameter int TX_MAX    = 16,
    parameter int PLL_RST   = 'h40,
    parameter int ADDR_RX   = 0,
    parameter int ADDR_TX   = 1,
    parameter int ADDR_PLL  = 4,
    parameter int ADDR_STAT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sel_n,
    input  logic              sdi,
    input  logic              clip_pulse,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_gain,
    output logic [DATA_W-1:0] tx_gain,
    output logic [DATA_W-1:0] pll_ctl
);

    logic              sclk_rise, sclk_fall, sel_act, sdi_s;
    logic [DATA_W-1:0] rd_data, wdata;
    logic [ADDR_W-1:0] rd_addr, acc_addr;
    logic              snap_load, commit_wr, commit_rd;

    afe_serctl_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sel_n     (sel_n),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sel_act   (sel_act),
        .sdi_s     (sdi_s)
    );

    afe_serctl_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_act   (sel_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .snap_load (snap_load),
        .acc_addr  (acc_addr),
        .wdata     (wdata),
        .commit_wr (commit_wr),
        .commit_rd (commit_rd),
        .sdo       (sdo)
    );

    afe_serctl_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RX_MAX    (RX_MAX),
        .TX_MAX    (TX_MAX),
        .RX_RST    (0),
        .TX_RST    (0),
        .PLL_RST   (PLL_RST),
        .ADDR_RX   (ADDR_RX),
        .ADDR_TX   (ADDR_TX),
        .ADDR_PLL  (ADDR_PLL),
        .ADDR_STAT (ADDR_STAT),
        .CLAMP_EN  (1'b1)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_wr  (commit_wr),
        .commit_rd  (commit_rd),
        .acc_addr   (acc_addr),
        .wdata      (wdata),
        .rd_addr    (rd_addr),
        .snap_load  (snap_load),
        .clip_pulse (clip_pulse),
        .rd_data    (rd_data),
        .rx_gain    (rx_gain),
        .tx_gain    (tx_gain),
        .pll_ctl    (pll_ctl)
    );

endmodule

// File: tb/afe_serctl_bench.sv
module afe_serctl_bench;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic       sdi = 1'b0;
    logic       clip_pulse = 1'b0;
    logic       sdo;
    logic [7:0] rx_gain, tx_gain, pll_ctl;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    string req   = "R1";

    // behavioural model
    logic [7:0] m_rx = 8'h00, m_tx = 8'h00, m_pll = 8'h40;
    bit         m_clip = 1'b0;
    logic       e_sdo = 1'b0;
    logic       p_sdo;
    logic [7:0] p_rx, p_tx, p_pll;

    always #5 clk = ~clk;

    afe_serctl u_afe_serctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .sel_n      (sel_n),
        .sdi        (sdi),
        .clip_pulse (clip_pulse),
        .sdo        (sdo),
        .rx_gain    (rx_gain),
        .tx_gain    (tx_gain),
        .pll_ctl    (pll_ctl)
    );

    task automatic chk(string r, string what, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, exp, $time);
        end
    endtask

    // compare every clock against the expectation one sample back (two-edge lag)
    always @(posedge clk) begin
        #3;
        if (!rst_n) begin
            p_sdo = e_sdo; p_rx = m_rx; p_tx = m_tx; p_pll = m_pll;
        end else begin
            chk(req, "sdo", {7'b0, sdo}, {7'b0, p_sdo});
            chk(req, "rx_gain", rx_gain, p_rx);
            chk(req, "tx_gain", tx_gain, p_tx);
            chk(req, "pll_ctl", pll_ctl, p_pll);
            p_sdo = e_sdo; p_rx = m_rx; p_tx = m_tx; p_pll = m_pll;
        end
    end

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0:    return m_rx;
            3'd1:    return m_tx;
            3'd4:    return m_pll;
            3'd7:    return {7'b0, m_clip};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_defaults();
        m_rx = 8'h00; m_tx = 8'h00; m_pll = 8'h40; m_clip = 1'b0; e_sdo = 1'b0;
    endtask

    // one access of nclk serial periods; rw=1 read, 0 write
    task automatic frame(bit rw, logic [2:0] a, logic [7:0] d, int nclk);
        logic [11:0] bits;
        logic [7:0]  rdv;
        bit          snap;
        bits = {rw, a, d};
        rdv  = m_read(a);
        snap = (a == 3'd7) && m_clip;
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b1;
            sdi  = (i < 12) ? bits[11-i] : 1'b0;
            if (rw && i >= 4 && i <= 11) e_sdo = rdv[11-i];
            else if (rw && i >= 12)      e_sdo = 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        sel_n = 1'b1;
        e_sdo = 1'b0;
        if (nclk == 12) begin
            if (!rw) begin
                if (a == 3'd0) m_rx  = (d > 8'd80) ? 8'd80 : d;
                if (a == 3'd1) m_tx  = (d > 8'd16) ? 8'd16 : d;
                if (a == 3'd4) m_pll = d;
            end else if (snap) begin
                m_clip = 1'b0;
            end
        end
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic pulse_clip();
        @(negedge clk);
        clip_pulse = 1'b1;
        m_clip = 1'b1;
        @(negedge clk);
        clip_pulse = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports and via reads
        req = "R1";
        chk("R1", "rx after reset", rx_gain, 8'h00);
        chk("R1", "tx after reset", tx_gain, 8'h00);
        chk("R1", "pll after reset", pll_ctl, 8'h40);
        chk("R1", "sdo after reset", {7'b0, sdo}, 8'h00);
        frame(1, 3'd0, 8'h00, 12);
        frame(1, 3'd1, 8'h00, 12);
        frame(1, 3'd4, 8'h00, 12);
        frame(1, 3'd7, 8'h00, 12);

        // R2 and R3: frame format and receive gain limit
        req = "R2";
        frame(0, 3'd0, 8'h2A, 12);
        frame(1, 3'd0, 8'h00, 12);
        req = "R3";
        frame(0, 3'd0, 8'd80, 12);
        frame(1, 3'd0, 8'h00, 12);
        frame(0, 3'd0, 8'hFF, 12);
        chk("R3", "rx clamp", rx_gain, 8'd80);
        frame(0, 3'd0, 8'd81, 12);
        frame(1, 3'd0, 8'h00, 12);

        // R4 transmit gain limit
        req = "R4";
        frame(0, 3'd1, 8'd16, 12);
        frame(0, 3'd1, 8'd17, 12);
        chk("R4", "tx clamp", tx_gain, 8'd16);
        frame(0, 3'd1, 8'd5, 12);
        frame(1, 3'd1, 8'h00, 12);

        // R5 PLL byte, R6 read launch pattern
        req = "R5";
        frame(0, 3'd4, 8'hA5, 12);
        chk("R5", "pll write", pll_ctl, 8'hA5);
        req = "R6";
        frame(1, 3'd4, 8'h00, 12);
        frame(1, 3'd4, 8'h00, 13);
        frame(1, 3'd4, 8'h00, 9);

        // R8 ignored writes and zero reads
        req = "R8";
        frame(0, 3'd2, 8'hFF, 12);
        frame(0, 3'd3, 8'hFF, 12);
        frame(0, 3'd5, 8'hFF, 12);
        frame(0, 3'd6, 8'hFF, 12);
        frame(0, 3'd7, 8'hFF, 12);
        frame(1, 3'd2, 8'h00, 12);
        frame(1, 3'd6, 8'h00, 12);
        frame(1, 3'd7, 8'h00, 12);

        // R7 wrong-length accesses change nothing
        req = "R7";
        frame(0, 3'd0, 8'h11, 11);
        frame(0, 3'd0, 8'h11, 13);
        frame(0, 3'd4, 8'h3C, 3);
        chk("R7", "rx untouched", rx_gain, 8'd5 == 8'd5 ? 8'd80 : 8'd0);
        pulse_clip();
        frame(1, 3'd7, 8'h00, 11);

        // R9 clip flag readback (returns 1, clears)
        req = "R9";
        frame(1, 3'd7, 8'h00, 12);
        pulse_clip();
        frame(1, 3'd7, 8'h00, 12);

        // R10 clear after reported read; late pulse survives
        req = "R10";
        frame(1, 3'd7, 8'h00, 12);
        fork
            frame(1, 3'd7, 8'h00, 12);
            begin
                repeat (16 * HALF) @(negedge clk);
                pulse_clip();
            end
        join
        frame(1, 3'd7, 8'h00, 12);
        frame(1, 3'd7, 8'h00, 12);

        // R1 asynchronous reset restores defaults
        req = "R1";
        frame(0, 3'd1, 8'd9, 12);
        pulse_clip();
        #2 rst_n = 1'b0;
        m_defaults();
        repeat (2) @(negedge clk);
        chk("R1", "pll during reset", pll_ctl, 8'h40);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "tx after reset", tx_gain, 8'h00);
        frame(1, 3'd7, 8'h00, 12);
        frame(1, 3'd4, 8'h00, 12);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule